// File: doc/BRIEF.md
# Bus-width matching adapter for a 36-bit FIFO

This block sits between the external write and read ports and a FIFO whose storage is 36 bits wide. On the write side it collects 9-bit or 18-bit words into full 36-bit entries and pushes each entry only after its last segment arrives. On the read side it pops one 36-bit entry and hands it out as a run of 18-bit or 9-bit words. It pops the next entry only once the final segment of the previous one has gone out. One mode is a plain 36-to-36 pass-through.

The width pairing and the segment order are captured while master reset is held. After that they stay fixed whatever the configuration pins do. A partial reset throws away any half-built or half-emitted entry but keeps the captured configuration. All logic runs on one clock. Both resets are synchronous and active low.

The design has three state machines. The configuration latch holds an enumerated mode: `MODE_W36_R36`, `MODE_W36_R18`, `MODE_W36_R9`, `MODE_W18_R36` or `MODE_W9_R36`. It reloads that mode on every clock while master reset is low.

The packer has two states, `PK_EMPTY` and `PK_PARTIAL`:
- A write that completes an entry pushes it and moves to or stays in `PK_EMPTY` (transition *commit*).
- Any other write moves to or stays in `PK_PARTIAL` (transition *accumulate*).

The unpacker has two states, `UP_IDLE` and `UP_DRAIN`:
- In `UP_IDLE`, a read request with the FIFO not empty pops an entry and emits its first segment (*fetch*). It then moves to `UP_DRAIN` if more segments remain.
- In `UP_DRAIN`, each read request emits the next segment (*drain*).
- Emitting the last segment returns it to `UP_IDLE` (*finish*).

Either reset forces `PK_EMPTY` and `UP_IDLE`.

Top module: `bus_width_adapter`

## Requirements
- R1: While `mrst_n` is low, the mode is decoded from `cfg_bm`, `cfg_iw` and `cfg_ow`. Later changes on these pins and on `cfg_le` have no effect. The decode is:
  - `cfg_bm`=0 gives 36 in, 36 out, whatever `cfg_iw` and `cfg_ow` are.
  - With `cfg_bm`=1, {`cfg_iw`,`cfg_ow`} = 00 gives 36 in, 18 out.
  - 01 gives 36 in, 9 out.
  - 10 gives 18 in, 36 out.
  - 11 gives 9 in, 36 out.
- R2: In 36-bit write mode, every cycle with `in_en` high gives `push`=1 and `push_data`=`in_data` in the next cycle. In 36-bit read mode, every `out_en` with the FIFO not empty pops once, and the next cycle shows `out_valid`=1 with `out_data`=`pop_data`.
- R3: In 9-bit write mode, four writes form one entry. `push` is high only in the cycle after the fourth write.
- R4: In 18-bit write mode, two writes form one entry. `push` is high only in the cycle after the second write.
- R5: In 18-bit read mode, each popped entry is emitted as two 18-bit words on `out_data[17:0]`, one per `out_en`, each appearing in the cycle after its request.
- R6: In 9-bit read mode, each popped entry is emitted as four 9-bit words on `out_data[8:0]`, one per `out_en`, each appearing in the cycle after its request.
- R7: Segment order depends on `cfg_le` captured at master reset.
  - `cfg_le`=0 (big-endian): the first narrow word written, or read, occupies the most significant segment of the entry.
  - `cfg_le`=1 (little-endian): it occupies the least significant segment. Later words take the next segment in that direction.
- R8: In narrow write modes, `in_data` bits above the narrow width are ignored. In narrow read modes, the `out_data` bits above the narrow width are driven 0.
- R9: `pop` is high only when a read request arrives with no partly emitted entry and `fifo_empty` low. A read request with no entry held and the FIFO empty causes no pop and leaves `out_valid` low in the next cycle.
- R10: A low `prst_n` discards any partly packed or partly unpacked entry and keeps the captured mode and order. The next entry is built from, or read starting with, the words that follow the reset.
- R11: While either reset is low, and in the first cycle after it, `push` and `out_valid` are 0. During reset, `push_data` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, active low; captures configuration |
| prst_n | input | 1 | Partial reset, active low; keeps configuration |
| cfg_bm | input | 1 | Width-matching enable, sampled at master reset |
| cfg_iw | input | 1 | Input-width select, sampled at master reset |
| cfg_ow | input | 1 | Output-width select, sampled at master reset |
| cfg_le | input | 1 | 0 big-endian, 1 little-endian, sampled at master reset |
| in_en | input | 1 | Write enable for one input word |
| in_data | input | 36 | Input word; low 9 or 18 bits used in narrow modes |
| push | output | 1 | Pushes `push_data` into the FIFO |
| push_data | output | 36 | Assembled entry |
| fifo_empty | input | 1 | FIFO holds no entry |
| pop_data | input | 36 | FIFO head entry, valid while not empty |
| pop | output | 1 | Removes the head entry from the FIFO |
| out_en | input | 1 | Read request for one output word |
| out_valid | output | 1 | `out_data` carries a word this cycle |
| out_data | output | 36 | Output word; upper bits 0 in narrow modes |

## Verification
All five width pairings are swept under both segment orders. Each input word carries random-looking bits above its narrow width, so writes that leak upper bits or place segments in the wrong order give different entries. Reads use entries whose segments all differ, which separates segment order, segment width and missing zero-fill of the upper output bits. Partial-reset runs stop mid-entry on both sides, showing whether the stale fragment is dropped and whether the mode survives. Read requests against an empty FIFO show whether a pop or an output can appear without an entry.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    typedef enum logic [2:0] {
        MODE_W36_R36,
        MODE_W36_R18,
        MODE_W36_R9,
        MODE_W18_R36,
        MODE_W9_R36
    } bwa_mode_e;

    typedef enum logic {
        PK_EMPTY,
        PK_PARTIAL
    } pk_state_e;

    typedef enum logic {
        UP_IDLE,
        UP_DRAIN
    } up_state_e;
endpackage

// File: rtl/bwa_mode_latch.sv
module bwa_mode_latch
    import bwa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int UL_W  = 2
) (
    input  logic            clk,
    input  logic            mrst_n,
    input  logic            cfg_bm,
    input  logic            cfg_iw,
    input  logic            cfg_ow,
    input  logic            cfg_le,
    output logic [UL_W-1:0] in_ul,
    output logic [UL_W-1:0] out_ul,
    output logic            big
);
    localparam int FULL_UL = $clog2(LANES);
    localparam int HALF_UL = FULL_UL - 1;

    bwa_mode_e mode_q;
    bwa_mode_e mode_dec;
    logic      big_q;

    always_comb begin
        if (!cfg_bm) begin
            mode_dec = MODE_W36_R36;
        end else begin
            unique case ({cfg_iw, cfg_ow})
                2'b00:   mode_dec = MODE_W36_R18;
                2'b01:   mode_dec = MODE_W36_R9;
                2'b10:   mode_dec = MODE_W18_R36;
                default: mode_dec = MODE_W9_R36;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= mode_dec;
            big_q  <= !cfg_le;
        end
    end

    always_comb begin
        in_ul  = UL_W'(FULL_UL);
        out_ul = UL_W'(FULL_UL);
        unique case (mode_q)
            MODE_W36_R36: ;
            MODE_W36_R18: out_ul = UL_W'(HALF_UL);
            MODE_W36_R9:  out_ul = '0;
            MODE_W18_R36: in_ul  = UL_W'(HALF_UL);
            MODE_W9_R36:  in_ul  = '0;
            default: ;
        endcase
    end

    assign big = big_q;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> ($stable(mode_q) && $stable(big_q)));
endmodule

// File: rtl/bwa_packer.sv
module bwa_packer
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int UL_W   = 2,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic [UL_W-1:0]         ul,
    input  logic                    big,
    input  logic                    in_en,
    input  logic [LANE_W*LANES-1:0] in_data,
    output logic                    push,
    output logic [LANE_W*LANES-1:0] push_data
);
    localparam int WIDE_W = LANE_W * LANES;

    pk_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx, pos;
    logic [WIDE_W-1:0] asm_q, asm_d, asm_fill;
    logic              commit;

    assign last_idx = CNT_W'((LANES >> ul) - 1);
    assign pos      = big ? (last_idx - cnt_q) : cnt_q;
    assign commit   = in_en && (cnt_q == last_idx);

    always_comb begin
        asm_fill = asm_q;
        for (int L = 0; L < LANES; L++) begin
            if ((L >> ul) == int'(pos)) begin
                asm_fill[L*LANE_W +: LANE_W] =
                    in_data[(L - (int'(pos) << ul))*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        asm_d   = asm_q;
        if (in_en) begin
            unique case (state_q)
                PK_EMPTY, PK_PARTIAL: begin
                    if (commit) begin
                        state_d = PK_EMPTY;
                        cnt_d   = '0;
                        asm_d   = '0;
                    end else begin
                        state_d = PK_PARTIAL;
                        cnt_d   = cnt_q + 1'b1;
                        asm_d   = asm_fill;
                    end
                end
                default: state_d = PK_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= PK_EMPTY;
            cnt_q   <= '0;
            asm_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            asm_q   <= asm_d;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            push      <= 1'b0;
            push_data <= '0;
        end else begin
            push <= commit;
            if (commit) push_data <= asm_fill;
        end
    end

    // R3
    push_after_write_chk: assert property (@(posedge clk) disable iff (clr)
        push |-> $past(in_en));

    // R10
    clear_drops_partial_chk: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> (!push && state_q == PK_EMPTY));
endmodule

// File: rtl/bwa_unpacker.sv
module bwa_unpacker
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter int UL_W   = 2,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic [UL_W-1:0]         ul,
    input  logic                    big,
    input  logic                    out_en,
    input  logic                    fifo_empty,
    input  logic [LANE_W*LANES-1:0] pop_data,
    output logic                    pop,
    output logic                    out_valid,
    output logic [LANE_W*LANES-1:0] out_data
);
    localparam int WIDE_W = LANE_W * LANES;

    up_state_e         state_q, state_d;
    logic [CNT_W-1:0]  idx_q, idx_d, last_idx, pos;
    logic [WIDE_W-1:0] ent_q, ent_d, src, seg;
    logic              take;

    assign last_idx = CNT_W'((LANES >> ul) - 1);
    assign pos      = big ? (last_idx - idx_q) : idx_q;
    assign pop      = out_en && (state_q == UP_IDLE) && !fifo_empty;
    assign take     = pop || (out_en && (state_q == UP_DRAIN));
    assign src      = (state_q == UP_IDLE) ? pop_data : ent_q;

    always_comb begin
        seg = '0;
        for (int L = 0; L < LANES; L++) begin
            if (L < (1 << ul)) begin
                seg[L*LANE_W +: LANE_W] =
                    src[((int'(pos) << ul) + L)*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        ent_d   = ent_q;
        if (take) begin
            unique case (state_q)
                UP_IDLE: begin
                    ent_d = pop_data;
                    if (last_idx != '0) begin
                        state_d = UP_DRAIN;
                        idx_d   = CNT_W'(1);
                    end
                end
                UP_DRAIN: begin
                    if (idx_q == last_idx) begin
                        state_d = UP_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                default: state_d = UP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= UP_IDLE;
            idx_q   <= '0;
            ent_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            ent_q   <= ent_d;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take;
            if (take) out_data <= seg;
        end
    end

    // R9
    pop_gives_word_chk: assert property (@(posedge clk) disable iff (clr)
        pop |=> out_valid);

    // R2
    valid_needs_request_chk: assert property (@(posedge clk) disable iff (clr)
        out_valid |-> $past(out_en));
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    mrst_n,
    input  logic                    prst_n,
    input  logic                    cfg_bm,
    input  logic                    cfg_iw,
    input  logic                    cfg_ow,
    input  logic                    cfg_le,
    input  logic                    in_en,
    input  logic [LANE_W*LANES-1:0] in_data,
    output logic                    push,
    output logic [LANE_W*LANES-1:0] push_data,
    input  logic                    fifo_empty,
    input  logic [LANE_W*LANES-1:0] pop_data,
    output logic                    pop,
    input  logic                    out_en,
    output logic                    out_valid,
    output logic [LANE_W*LANES-1:0] out_data
);
    localparam int UL_W  = $clog2($clog2(LANES) + 1);
    localparam int CNT_W = $clog2(LANES);

    logic            clr;
    logic [UL_W-1:0] in_ul, out_ul;
    logic            big;

    assign clr = !mrst_n || !prst_n;

    bwa_mode_latch #(.LANES(LANES), .UL_W(UL_W)) u_mode (
        .clk(clk), .mrst_n(mrst_n), .cfg_bm(cfg_bm), .cfg_iw(cfg_iw),
        .cfg_ow(cfg_ow), .cfg_le(cfg_le), .in_ul(in_ul), .out_ul(out_ul),
        .big(big)
    );

    bwa_packer #(.LANE_W(LANE_W), .LANES(LANES), .UL_W(UL_W), .CNT_W(CNT_W)) u_pack (
        .clk(clk), .clr(clr), .ul(in_ul), .big(big), .in_en(in_en),
        .in_data(in_data), .push(push), .push_data(push_data)
    );

    bwa_unpacker #(.LANE_W(LANE_W), .LANES(LANES), .UL_W(UL_W), .CNT_W(CNT_W)) u_unpack (
        .clk(clk), .clr(clr), .ul(out_ul), .big(big), .out_en(out_en),
        .fifo_empty(fifo_empty), .pop_data(pop_data), .pop(pop),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;
    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1;
    logic        cfg_bm = 1'b0, cfg_iw = 1'b0, cfg_ow = 1'b0, cfg_le = 1'b0;
    logic        in_en = 1'b0, out_en = 1'b0;
    logic [35:0] in_data = '0;
    logic        push, pop, out_valid, fifo_empty;
    logic [35:0] push_data, pop_data, out_data;

    logic [35:0] fmem [16];
    int          head = 0, tail = 0;
    int          checks = 0, failures = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign fifo_empty = (head == tail);
    assign pop_data   = fmem[head[3:0]];
    always @(posedge clk) if (pop) head <= head + 1;

    bus_width_adapter u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_bm(cfg_bm),
        .cfg_iw(cfg_iw), .cfg_ow(cfg_ow), .cfg_le(cfg_le), .in_en(in_en),
        .in_data(in_data), .push(push), .push_data(push_data),
        .fifo_empty(fifo_empty), .pop_data(pop_data), .pop(pop),
        .out_en(out_en), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] seg_mask(input int ul);
        return (36'd1 << (9 << ul)) - 36'd1;
    endfunction

    task automatic master_reset(input int m, input bit le);
        @(negedge clk);
        mrst_n = 1'b0;
        cfg_bm = (m != 0);
        cfg_iw = (m >= 3);
        cfg_ow = (m == 2) || (m == 4);
        cfg_le = le;
        @(negedge clk);
        @(negedge clk);
        // R11 outputs cleared while reset is held
        check("R11 push", {35'd0, push}, 36'd0);
        check("R11 out_valid", {35'd0, out_valid}, 36'd0);
        check("R11 push_data", push_data, 36'd0);
        check("R11 out_data", out_data, 36'd0);
        mrst_n = 1'b1;
        // R1 configuration pins scrambled after reset must have no effect
        cfg_bm = ~cfg_bm; cfg_iw = ~cfg_iw; cfg_ow = ~cfg_ow; cfg_le = ~cfg_le;
        @(negedge clk);
        check("R11 push after reset", {35'd0, push}, 36'd0);
    endtask

    task automatic write_word(input string tag, input logic [35:0] w,
                              input bit exp_push, input logic [35:0] exp_data);
        in_en = 1'b1;
        in_data = w;
        @(negedge clk);
        in_en = 1'b0;
        in_data = 36'h0;
        check({tag, " push"}, {35'd0, push}, {35'd0, exp_push});
        if (exp_push) check({tag, " push_data"}, push_data, exp_data);
    endtask

    task automatic read_word(input string tag, input bit exp_pop, input logic [35:0] exp_data);
        out_en = 1'b1;
        #1;
        check({tag, " pop"}, {35'd0, pop}, {35'd0, exp_pop});
        @(negedge clk);
        out_en = 1'b0;
        check({tag, " out_valid"}, {35'd0, out_valid}, 36'd1);
        check({tag, " out_data"}, out_data, exp_data);
    endtask

    task automatic load(input logic [35:0] e);
        fmem[tail[3:0]] = e;
        tail++;
    endtask

    function automatic logic [35:0] garbage(input int r, input int i);
        return 36'h9_A5C3_3C5A ^ (36'(r * 131 + i * 977) * 36'h0_0F1E_2D3B);
    endfunction

    function automatic logic [35:0] entry_val(input int r, input int i);
        return 36'h1_2345_6789 * 36'(i + 3) + 36'(r * 12345);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 5; m++) begin
            for (int le = 0; le < 2; le++) begin
                int in_ul, out_ul, nin, nout, run;
                string wtag, rtag;
                bit big;
                run = m * 2 + le;
                big = (le == 0);
                in_ul  = (m == 3) ? 1 : (m == 4) ? 0 : 2;
                out_ul = (m == 1) ? 1 : (m == 2) ? 0 : 2;
                nin  = 4 >> in_ul;
                nout = 4 >> out_ul;
                wtag = (m == 4) ? "R3/R7/R8" : (m == 3) ? "R4/R7/R8" : "R2";
                rtag = (m == 2) ? "R6/R7/R8" : (m == 1) ? "R5/R7/R8" : "R2";
                master_reset(m, le[0]);

                // packing: three entries
                for (int j = 0; j < 3; j++) begin
                    logic [35:0] exp_e;
                    exp_e = '0;
                    for (int k = 0; k < nin; k++) begin
                        logic [35:0] w;
                        int p;
                        w = garbage(run, j * 4 + k);
                        p = big ? (nin - 1 - k) : k;
                        exp_e |= (w & seg_mask(in_ul)) << (p * (9 << in_ul));
                        write_word(wtag, w, k == nin - 1, exp_e);
                    end
                end

                // R9 read request with empty FIFO and no held entry
                out_en = 1'b1;
                #1;
                check("R9 pop on empty", {35'd0, pop}, 36'd0);
                @(negedge clk);
                out_en = 1'b0;
                check("R9 valid on empty", {35'd0, out_valid}, 36'd0);

                // unpacking: three entries
                for (int j = 0; j < 3; j++) load(entry_val(run, j));
                for (int j = 0; j < 3; j++) begin
                    for (int k = 0; k < nout; k++) begin
                        int p;
                        p = big ? (nout - 1 - k) : k;
                        read_word(rtag, k == 0,
                                  (entry_val(run, j) >> (p * (9 << out_ul))) & seg_mask(out_ul));
                    end
                end
                check("R9 fifo drained", {35'd0, fifo_empty}, 36'd1);
            end
        end

        // R10 partial reset mid-pack, 9-bit write, big-endian
        master_reset(4, 1'b0);
        write_word("R10 pre", 36'h0_0000_01AB, 1'b0, 36'h0);
        write_word("R10 pre", 36'h0_0000_0155, 1'b0, 36'h0);
        prst_n = 1'b0;
        @(negedge clk);
        check("R10 push in prst", {35'd0, push}, 36'd0);
        prst_n = 1'b1;
        @(negedge clk);
        write_word("R10 post", 36'hF_FFFF_F001, 1'b0, 36'h0);
        write_word("R10 post", 36'hF_FFFF_F002, 1'b0, 36'h0);
        write_word("R10 post", 36'hF_FFFF_F003, 1'b0, 36'h0);
        write_word("R10 post", 36'hF_FFFF_F004, 1'b1,
                   {9'h001, 9'h002, 9'h003, 9'h004});

        // R10 partial reset mid-unpack, 9-bit read, little-endian
        master_reset(2, 1'b1);
        load(36'h1_1122_3344);
        load({9'h1AA, 9'h0BB, 9'h1CC, 9'h0DD});
        read_word("R10 first", 1'b1, 36'h1_1122_3344 & 36'h1FF);
        read_word("R10 second", 1'b0, (36'h1_1122_3344 >> 9) & 36'h1FF);
        prst_n = 1'b0;
        @(negedge clk);
        check("R10 valid in prst", {35'd0, out_valid}, 36'd0);
        prst_n = 1'b1;
        @(negedge clk);
        read_word("R10 new entry", 1'b1, 36'h0DD);
        read_word("R10 new entry", 1'b0, 36'h1CC);
        read_word("R10 new entry", 1'b0, 36'h0BB);
        read_word("R10 new entry", 1'b0, 36'h1AA);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule